// File: doc/BRIEF.md
# Microwire Serial EEPROM Master

This block drives a three-wire Microwire serial EEPROM of 64 words, each 16 bits wide. The host presents an operation code, a 6-bit word address and, for writes, a 16-bit data word. It then pulses start for one cycle. The block builds the command frame, raises an active-high chip select and generates the serial clock from the system clock. It shifts the frame out most significant bit first. For reads it collects the returned 16-bit word.

Read and write transactions have two phases inside one chip-select window: a command phase, then a 16-bit data phase. A read puts a single zero bit after the 9 command bits. The erase-one operation and the three special commands (erase/write enable, erase/write disable, erase-all) are a single 9-bit phase. When a transaction ends, chip select falls and a one-cycle done pulse is raised. A start request made while the block is busy is refused and reported with a one-cycle pulse.

Top module: `mw_eeprom_master`

## Requirements
- R1: Every frame begins with a start bit of 1, then the 2-bit opcode, then the 6-bit address, sent MSB first. Opcodes are: 2'b10 read, 2'b01 write, 2'b11 erase one word, 2'b00 special. For special commands, addr_i[5:4] selects the command: 2'b00 disables erase/write, 2'b01 writes all words, 2'b10 erases all words, 2'b11 enables erase/write.
- R2: A read clocks out 10 bits (the command plus one 0 bit), then clocks in 16 data bits MSB first, for 26 serial clocks in total. The received word appears on rdata_o in the cycle done_o is high.
- R3: A write, and a write-all, send wdata_i MSB first straight after the 9 command bits, for 25 serial clocks in one chip-select window.
- R4: Erase-one, erase-all, enable and disable send exactly 9 serial clocks, and chip select then falls.
- R5: Chip select stays high from the accepted start until the end of the frame. done_o is high for exactly one cycle, in the cycle chip select has just fallen.
- R6: While idle, cs_o is low, sck_o is high and ready_o is high. ready_o is low during a transaction.
- R7: A start made while ready_o is low gives a one-cycle refused_o pulse in the next cycle. It does not disturb the transaction in progress.
- R8: sck_o has a period of 2*HALF_DIV system clocks. sdo_o changes only while sck_o is low or at the end of the frame. sdi_i is sampled on the rising edge of sck_o.
- R9: After reset the block is idle: cs_o low, sck_o high, sdo_o low, done_o and refused_o low.
- R10: An erased word reads back as 16'hFFFF through the read transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one cycle |
| op_i | input | 2 | Operation code |
| addr_i | input | 6 | Word address, or special command select in bits 5:4 |
| wdata_i | input | 16 | Write data |
| ready_o | output | 1 | Idle and able to accept a start |
| refused_o | output | 1 | Start was refused because the block was busy |
| done_o | output | 1 | Transaction finished, one cycle |
| rdata_o | output | 16 | Word received by the last read |
| cs_o | output | 1 | Chip select, active high |
| sck_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data to the EEPROM |
| sdi_i | input | 1 | Serial data from the EEPROM |

## Verification
The hardest case to reach from the ports is the boundary between the phases of a two-phase frame. Chip select must not move there, and the read's dummy bit must not be taken as data. A behavioural EEPROM in the bench decodes each chip-select window by its clock count. Every one of the 64 words is written with an address-derived pattern and read back. A wrong phase length or a dropped bit would therefore garble the decoded command or shift the returned word. The bench also issues starts in the middle of a frame, and it writes while writing is disabled, to show that neither has an effect.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {
    OP_SPECIAL = 2'b00,
    OP_WRITE   = 2'b01,
    OP_READ    = 2'b10,
    OP_ERASE   = 2'b11
  } mw_op_e;

  typedef enum logic [1:0] {
    SP_DISABLE   = 2'b00,
    SP_WRITE_ALL = 2'b01,
    SP_ERASE_ALL = 2'b10,
    SP_ENABLE    = 2'b11
  } mw_special_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SHIFT = 2'b01,
    ST_CLOSE = 2'b10
  } mw_state_e;
endpackage

// File: rtl/mw_tick.sv
module mw_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!run_i || cnt_q == LAST) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/mw_frame.sv
module mw_frame
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  localparam int CMD_W   = 3 + ADDR_W,
  localparam int FRAME_W = CMD_W + 1 + DATA_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [1:0]         op_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   len_o,
  output logic               rx_en_o
);
  logic [CMD_W-1:0] cmd;
  logic             carries_data;

  assign cmd = {1'b1, op_i, addr_i};
  assign carries_data = (op_i == OP_WRITE) ||
                        (op_i == OP_SPECIAL && addr_i[ADDR_W-1 -: 2] == SP_WRITE_ALL);

  always_comb begin
    rx_en_o = 1'b0;
    if (op_i == OP_READ) begin
      frame_o = {cmd, 1'b0, {DATA_W{1'b0}}};
      len_o   = CNT_W'(FRAME_W);
      rx_en_o = 1'b1;
    end else if (carries_data) begin
      frame_o = {cmd, wdata_i, 1'b0};
      len_o   = CNT_W'(CMD_W + DATA_W);
    end else begin
      frame_o = {cmd, {(DATA_W + 1){1'b0}}};
      len_o   = CNT_W'(CMD_W);
    end
  end
endmodule

// File: rtl/mw_shifter.sv
module mw_shifter
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  localparam int CMD_W   = 3 + ADDR_W,
  localparam int FRAME_W = CMD_W + 1 + DATA_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   len_i,
  input  logic               rx_en_i,
  input  logic               sdi_i,
  output logic               run_o,
  output logic               ready_o,
  output logic               refused_o,
  output logic               done_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               cs_o,
  output logic               sck_o,
  output logic               sdo_o
);
  localparam logic [CNT_W-1:0] RX_FIRST = CNT_W'(CMD_W + 1);

  mw_state_e          state_q;
  logic [FRAME_W-1:0] sreg_q;
  logic [CNT_W-1:0]   bit_cnt_q, len_q;
  logic               rx_en_q;
  logic [DATA_W-1:0]  rx_q;

  assign ready_o = (state_q == ST_IDLE);
  assign run_o   = !ready_o;
  assign rdata_o = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sreg_q    <= '0;
      bit_cnt_q <= '0;
      len_q     <= '0;
      rx_en_q   <= 1'b0;
      rx_q      <= '0;
      cs_o      <= 1'b0;
      sck_o     <= 1'b1;
      sdo_o     <= 1'b0;
      done_o    <= 1'b0;
      refused_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      refused_o <= start_i && !ready_o;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          sreg_q    <= frame_i;
          len_q     <= len_i;
          rx_en_q   <= rx_en_i;
          bit_cnt_q <= '0;
          cs_o      <= 1'b1;
          state_q   <= ST_SHIFT;
        end
        ST_SHIFT: if (tick_i) begin
          if (sck_o) begin
            // falling edge: present next bit
            sck_o  <= 1'b0;
            sdo_o  <= sreg_q[FRAME_W-1];
            sreg_q <= sreg_q << 1;
          end else begin
            // rising edge: slave samples sdo, we sample sdi
            sck_o <= 1'b1;
            if (rx_en_q && bit_cnt_q >= RX_FIRST) rx_q <= {rx_q[DATA_W-2:0], sdi_i};
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q + 1'b1 == len_q) state_q <= ST_CLOSE;
          end
        end
        ST_CLOSE: if (tick_i) begin
          cs_o    <= 1'b0;
          sdo_o   <= 1'b0;
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_cs_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> done_o);
  assert_done_cs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cs_o && $past(cs_o));
  assert_idle_lines_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !cs_o && sck_o);
  assert_refuse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refused_o |-> $past(start_i) && !$past(ready_o));
  assert_sdo_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> !sck_o || done_o);
  assert_frame_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> bit_cnt_q == len_q);
endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master #(
  parameter int HALF_DIV = 4,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              refused_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cs_o,
  output logic              sck_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  localparam int CMD_W   = 3 + ADDR_W;
  localparam int FRAME_W = CMD_W + 1 + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   len;
  logic               rx_en, run, tick;

  mw_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .op_i(op_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .frame_o(frame), .len_o(len), .rx_en_o(rx_en)
  );

  mw_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_o(tick)
  );

  mw_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .start_i(start_i),
    .frame_i(frame), .len_i(len), .rx_en_i(rx_en), .sdi_i(sdi_i),
    .run_o(run), .ready_o(ready_o), .refused_o(refused_o), .done_o(done_o),
    .rdata_o(rdata_o), .cs_o(cs_o), .sck_o(sck_o), .sdo_o(sdo_o)
  );
endmodule

// File: tb/mw_eeprom_master_tb.sv
module mw_eeprom_master_tb;
  localparam int HALF_DIV = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = '0;
  logic [5:0] addr = '0;
  logic [15:0] wdata = '0;
  logic ready, refused, done, cs, sck, sdo;
  logic [15:0] rdata;
  logic sdi = 1'b0;

  int checks = 0, failures = 0;
  longint cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mw_eeprom_master #(.HALF_DIV(HALF_DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .op_i(op), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .refused_o(refused), .done_o(done),
    .rdata_o(rdata), .cs_o(cs), .sck_o(sck), .sdo_o(sdo), .sdi_i(sdi)
  );

  // behavioural EEPROM
  logic [15:0] mem [64];
  logic        wr_en = 1'b0;
  logic [31:0] rbits;
  int          nbits = 0, last_nbits = 0;
  logic [8:0]  last_cmd;
  logic [15:0] rd_word;
  longint      last_fall = 0, fall_gap = 0;

  initial for (int i = 0; i < 64; i++) mem[i] = 16'h0000;

  always @(posedge cs) begin nbits = 0; last_fall = 0; end

  always @(posedge sck) if (cs) begin
    rbits = {rbits[30:0], sdo};
    nbits++;
    if (nbits == 10 && rbits[8:7] == 2'b10) rd_word = mem[rbits[6:1]];
  end

  always @(negedge sck) if (cs) begin
    if (last_fall != 0) fall_gap = cyc - last_fall;
    last_fall = cyc;
    if (nbits >= 10 && rbits[(nbits-1)-:2] != 2'b00 && last_cmd_is_read()) begin
      sdi <= rd_word[15];
      rd_word = rd_word << 1;
    end
  end

  function automatic bit last_cmd_is_read();
    return (nbits >= 10) && (rbits[nbits-2 -: 2] == 2'b10);
  endfunction

  always @(negedge cs) begin
    last_nbits = nbits;
    sdi <= 1'b0;
    if (nbits == 9) begin
      last_cmd = rbits[8:0];
      if (rbits[8]) begin
        if (rbits[7:6] == 2'b11 && wr_en) mem[rbits[5:0]] = 16'hFFFF;
        else if (rbits[7:6] == 2'b00) begin
          case (rbits[5:4])
            2'b00: wr_en = 1'b0;
            2'b11: wr_en = 1'b1;
            2'b10: if (wr_en) for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
            default: ;
          endcase
        end
      end
    end else if (nbits == 25) begin
      last_cmd = rbits[24:16];
      if (rbits[24] && wr_en) begin
        if (rbits[23:22] == 2'b01) mem[rbits[21:16]] = rbits[15:0];
        else if (rbits[23:22] == 2'b00 && rbits[21:20] == 2'b01)
          for (int i = 0; i < 64; i++) mem[i] = rbits[15:0];
      end
    end else if (nbits == 26) begin
      last_cmd = rbits[25:17];
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [5:0] a, input logic [15:0] d,
                        input int exp_len, input string req);
    int t;
    @(negedge clk);
    t = 0;
    while (!ready && t < 10000) begin @(negedge clk); t++; end
    op = o; addr = a; wdata = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 10000) begin @(negedge clk); t++; end
    check(done && !cs, req, done, 1);
    check(last_nbits == exp_len, req, last_nbits, exp_len);
    check(last_cmd == {1'b1, o, a}, "R1", last_cmd, {1'b1, o, a});
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 16'h0403) ^ 16'h5A00;
  endfunction

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!cs && sck && !sdo && !done && !refused && ready, "R9", {cs, sck, sdo, done, refused}, 5'b01000);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(!cs && sck && ready, "R6", {cs, sck, ready}, 3'b011);

    run_op(2'b00, 6'b110000, 16'h0, 9, "R4");                 // enable
    for (int a = 0; a < 64; a++) run_op(2'b01, 6'(a), pat(a), 25, "R3");
    check(fall_gap == 2 * HALF_DIV, "R8", fall_gap, 2 * HALF_DIV);
    for (int a = 0; a < 64; a++) begin
      run_op(2'b10, 6'(a), 16'h0, 26, "R2");
      check(rdata == pat(a), "R2", rdata, pat(a));
    end

    // R7: start mid-frame is refused, frame intact
    @(negedge clk);
    op = 2'b10; addr = 6'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!ready && cs, "R6", ready, 0);
    repeat (30) @(negedge clk);
    op = 2'b01; addr = 6'd20; wdata = 16'hDEAD; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(refused, "R7", refused, 1);
    @(negedge clk);
    check(!refused, "R7", refused, 0);
    while (!done) @(negedge clk);
    check(rdata == pat(9) && last_nbits == 26, "R7", rdata, pat(9));
    run_op(2'b10, 6'd20, 16'h0, 26, "R2");
    check(rdata == pat(20), "R7", rdata, pat(20));

    // erase one word
    run_op(2'b11, 6'd7, 16'h0, 9, "R4");
    run_op(2'b10, 6'd7, 16'h0, 26, "R2");
    check(rdata == 16'hFFFF, "R10", rdata, 16'hFFFF);
    run_op(2'b10, 6'd8, 16'h0, 26, "R2");
    check(rdata == pat(8), "R10", rdata, pat(8));

    // disable, then write has no effect
    run_op(2'b00, 6'b000000, 16'h0, 9, "R4");
    run_op(2'b01, 6'd5, 16'h1111, 25, "R3");
    run_op(2'b10, 6'd5, 16'h0, 26, "R2");
    check(rdata == pat(5), "R3", rdata, pat(5));

    // write-all, then erase-all
    run_op(2'b00, 6'b110000, 16'h0, 9, "R4");
    run_op(2'b00, 6'b010000, 16'hA5C3, 25, "R3");
    for (int a = 0; a < 64; a += 21) begin
      run_op(2'b10, 6'(a), 16'h0, 26, "R2");
      check(rdata == 16'hA5C3, "R3", rdata, 16'hA5C3);
    end
    run_op(2'b00, 6'b100000, 16'h0, 9, "R4");
    for (int a = 1; a < 64; a += 31) begin
      run_op(2'b10, 6'(a), 16'h0, 26, "R2");
      check(rdata == 16'hFFFF, "R10", rdata, 16'hFFFF);
    end

    repeat (2 * HALF_DIV + 2) @(negedge clk);
    check(!cs && sck && ready && !done, "R5", {cs, sck, ready, done}, 4'b0110);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule